// File: doc/BRIEF.md
# Bus Turnaround Idle Cycle Inserter

This block stands between a stream of CPU-side access requests and an external memory bus split into four chip-select spaces. It remembers the direction and the space of the last bus access and counts the bus clocks in which no chip-select was active since then. Before the next access is granted, it works out how many idle clocks that access needs. If fewer have passed, it holds the request with `req_ready` low until the count is met. The aim is to keep a slow device that has just been read from driving the data bus while the next device starts.

The gap comes from a configuration vector with a 2-bit field for each space. It applies only when a read is followed by a write to the same space, or by any access to a different space. Idle clocks that have already passed are credited against the programmed gap. Back-to-back accesses to one space always get at least one clock with the chip-select negated, so the device can see where each bus cycle starts. Each accepted request produces a one-clock chip-select pulse on the following clock.

Top module: `bus_turn_gap`

## Requirements
- R1: After reset all chip-selects are inactive and the previous access counts as a write, so the first access is accepted with no gap.
- R2: A write to the same space directly after a read of that space is separated from it by the read space's programmed idle count, but by no fewer than one idle clock.
- R3: Any access to a different space directly after a read is separated from it by exactly the read space's programmed idle count, which may be zero.
- R4: Idle clocks that already passed since the last access count toward the required gap. Only the difference is inserted, and nothing is inserted once the gap is met.
- R5: Two accesses to the same space are always separated by at least one clock with every chip-select inactive.
- R6: After a write, an access to a different space needs no idle clock. An access to the same space needs only the single negation clock.
- R7: The idle count is a 2-bit field giving 0 to 3 clocks. The field for space k sits at bits [2k+1:2k] of `cfg_idle`, and the field used is that of the space read by the previous access.
- R8: When a request is accepted (`req_valid` and `req_ready` both high at a rising edge), exactly that space's chip-select (`cs_o[k]` for space k, active high) is asserted for the one following clock. Otherwise no chip-select is active.
- R9: While a request is being held, `req_ready` stays low and all chip-selects stay inactive.
- R10: The idle counter saturates at 3, so after a long idle period any access is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_idle | input | 8 | Idle count per space, 2 bits each, space k at [2k+1:2k] |
| req_valid | input | 1 | Access request present |
| req_space | input | 2 | Decoded chip-select space of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ready | output | 1 | Request may be accepted on this edge |
| cs_o | output | 4 | Per-space chip-select, active high, one clock per access |

## Verification
The bench issues pairs of accesses that cover all four transition kinds: read then write to the same space, read then another space, write then another space, and repeated accesses to one space. Several field settings are used, including zero, three and a mix of different values per space. This separates the read-space field from the requested-space field and the turnaround gap from the plain chip-select negation. Pairs with one, two and five idle clocks placed in front of the second request show whether existing idle time is credited or added on top, and whether the saturated counter lets long-idle accesses through at once. A reference model compares `req_ready` and `cs_o` on every clock, so any stalled or extra cycle is caught.

// File: rtl/bus_turn_pkg.sv
package bus_turn_pkg;

  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } bus_dir_e;

  // A read followed by a write or by a move to another space turns the bus around.
  function automatic logic is_turnaround(input bus_dir_e prev_dir,
                                         input bus_dir_e next_dir,
                                         input logic     same_space);
    return (prev_dir == DIR_READ) && ((next_dir == DIR_WRITE) || !same_space);
  endfunction

endpackage

// File: rtl/turn_idle_counter.sv
module turn_idle_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  output logic [CNT_W-1:0] idle_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)
      idle_cnt <= CNT_MAX;
    else if (clear)
      idle_cnt <= '0;
    else if (idle_cnt != CNT_MAX)
      idle_cnt <= idle_cnt + 1'b1;
  end

  // R10
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear && idle_cnt == CNT_MAX) |=> (idle_cnt == CNT_MAX));

  // R4
  idle_counts_chk: assert property (@(posedge clk) disable iff (rst)
    !clear |=> (idle_cnt != '0));
endmodule

// File: rtl/turn_history.sv
module turn_history
  import bus_turn_pkg::*;
#(
  parameter int SP_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            grant,
  input  logic [SP_W-1:0] req_space,
  input  bus_dir_e        req_dir,
  output logic [SP_W-1:0] prev_space,
  output bus_dir_e        prev_dir
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_space <= '0;
      prev_dir   <= DIR_WRITE;
    end else if (grant) begin
      prev_space <= req_space;
      prev_dir   <= req_dir;
    end
  end
endmodule

// File: rtl/turn_gap_calc.sv
module turn_gap_calc
  import bus_turn_pkg::*;
#(
  parameter int NUM_SPACES = 4,
  parameter int CFG_W      = 2,
  parameter int SP_W       = 2
) (
  input  logic [NUM_SPACES*CFG_W-1:0] cfg_idle,
  input  logic [SP_W-1:0]             prev_space,
  input  bus_dir_e                    prev_dir,
  input  logic [SP_W-1:0]             req_space,
  input  bus_dir_e                    req_dir,
  output logic [CFG_W-1:0]            need
);
  logic [CFG_W-1:0] field [NUM_SPACES];
  logic             same;

  for (genvar g = 0; g < NUM_SPACES; g++) begin : g_field
    assign field[g] = cfg_idle[g*CFG_W +: CFG_W];
  end

  assign same = (prev_space == req_space);

  always_comb begin
    need = '0;
    if (is_turnaround(prev_dir, req_dir, same))
      need = field[prev_space];
    if (same && need == '0)
      need = CFG_W'(1);
  end

  // R5
  always_comb begin
    same_negate_chk: assert (!same || need != '0);
  end
endmodule

// File: rtl/turn_cs_driver.sv
module turn_cs_driver #(
  parameter int NUM_SPACES = 4,
  parameter int SP_W       = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  grant,
  input  logic [SP_W-1:0]       req_space,
  output logic [NUM_SPACES-1:0] cs_o
);
  logic [NUM_SPACES-1:0] sel;

  for (genvar g = 0; g < NUM_SPACES; g++) begin : g_sel
    assign sel[g] = (req_space == SP_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst)
      cs_o <= '0;
    else if (grant)
      cs_o <= sel;
    else
      cs_o <= '0;
  end

  // R8
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs_o));

  // R8
  cs_follows_grant_chk: assert property (@(posedge clk) disable iff (rst)
    grant |=> cs_o[$past(req_space)]);
endmodule

// File: rtl/bus_turn_gap.sv
module bus_turn_gap
  import bus_turn_pkg::*;
#(
  parameter int NUM_SPACES = 4,
  parameter int CFG_W      = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_SPACES*CFG_W-1:0]         cfg_idle,
  input  logic                                req_valid,
  input  logic [$clog2(NUM_SPACES)-1:0]       req_space,
  input  logic                                req_write,
  output logic                                req_ready,
  output logic [NUM_SPACES-1:0]               cs_o
);
  localparam int SP_W = $clog2(NUM_SPACES);

  logic             grant;
  logic [CFG_W-1:0] idle_cnt;
  logic [CFG_W-1:0] need;
  logic [SP_W-1:0]  prev_space;
  bus_dir_e         prev_dir;
  bus_dir_e         req_dir;

  assign req_dir   = req_write ? DIR_WRITE : DIR_READ;
  assign req_ready = (idle_cnt >= need);
  assign grant     = req_valid && req_ready;

  turn_idle_counter #(.CNT_W(CFG_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clear    (grant),
    .idle_cnt (idle_cnt)
  );

  turn_history #(.SP_W(SP_W)) u_hist (
    .clk        (clk),
    .rst        (rst),
    .grant      (grant),
    .req_space  (req_space),
    .req_dir    (req_dir),
    .prev_space (prev_space),
    .prev_dir   (prev_dir)
  );

  turn_gap_calc #(.NUM_SPACES(NUM_SPACES), .CFG_W(CFG_W), .SP_W(SP_W)) u_gap (
    .cfg_idle   (cfg_idle),
    .prev_space (prev_space),
    .prev_dir   (prev_dir),
    .req_space  (req_space),
    .req_dir    (req_dir),
    .need       (need)
  );

  turn_cs_driver #(.NUM_SPACES(NUM_SPACES), .SP_W(SP_W)) u_cs (
    .clk       (clk),
    .rst       (rst),
    .grant     (grant),
    .req_space (req_space),
    .cs_o      (cs_o)
  );

  // R5
  cs_negate_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_o != '0) |=> ((cs_o & $past(cs_o)) == '0));

  // R9
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (cs_o == '0));
endmodule

// File: tb/bus_turn_gap_tb_top.sv
module bus_turn_gap_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg_idle = 8'h00;
  logic       req_valid = 1'b0;
  logic [1:0] req_space = 2'd0;
  logic       req_write = 1'b0;
  logic       req_ready;
  logic [3:0] cs_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  int         m_cnt = 3;
  int         m_psp = 0;
  bit         m_pwr = 1;
  logic [3:0] m_cs  = 4'b0;
  int         last_cs_cyc = -1;
  int         last_gap    = -1;

  bus_turn_gap dut_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_idle  (cfg_idle),
    .req_valid (req_valid),
    .req_space (req_space),
    .req_write (req_write),
    .req_ready (req_ready),
    .cs_o      (cs_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int need_of(input int sp, input bit wr);
    int n = 0;
    if (!m_pwr && (sp != m_psp || wr)) n = (int'(cfg_idle) >> (2 * m_psp)) & 3;
    if (sp == m_psp && n < 1) n = 1;
    return n;
  endfunction

  function automatic bit exp_ready();
    return m_cnt >= need_of(int'(req_space), req_write);
  endfunction

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_cnt = 3; m_psp = 0; m_pwr = 1; m_cs = 4'b0;
    end else if (req_valid && exp_ready()) begin
      m_cs  = 4'b0001 << req_space;
      m_cnt = 0;
      m_psp = int'(req_space);
      m_pwr = req_write;
    end else begin
      m_cs = 4'b0;
      if (m_cnt < 3) m_cnt++;
    end
  end

  // per-clock comparison and gap monitor, on the falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cs_o === m_cs, "R8 cs_o", int'(cs_o), int'(m_cs));
      chk(req_ready === exp_ready(), "R9 req_ready", int'(req_ready), int'(exp_ready()));
      if (cs_o != 4'b0) begin
        if (last_cs_cyc >= 0) last_gap = cyc - last_cs_cyc - 1;
        last_cs_cyc = cyc;
      end
    end
  end

  task automatic issue(input int sp, input bit wr);
    bit acc;
    req_valid = 1'b1;
    req_space = 2'(sp);
    req_write = wr;
    do begin
      @(negedge clk);
      acc = req_ready;
      @(posedge clk);
      #1;
    end while (!acc);
    req_valid = 1'b0;
  endtask

  task automatic pair(input int sp1, input bit wr1, input int idle,
                      input int sp2, input bit wr2, input int exp, input string tag);
    repeat (4) @(posedge clk);
    #1;
    issue(sp1, wr1);
    repeat (idle) @(posedge clk);
    if (idle > 0) #1;
    issue(sp2, wr2);
    @(negedge clk);
    #1;
    chk(last_gap == exp, tag, last_gap, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cfg_idle = 8'b11_10_01_00;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    chk(cs_o == 4'b0, "R1 reset cs", int'(cs_o), 0);
    req_space = 2'd2;
    req_write = 1'b0;
    #1;
    chk(req_ready == 1'b1, "R1 first ready", int'(req_ready), 1);
    @(posedge clk);
    #1;
    issue(2, 0);
    @(negedge clk);
    chk(cs_o == 4'b0100, "R1 R8 first cs", int'(cs_o), 4);

    // field per space: s0=0 s1=1 s2=2 s3=3
    pair(1, 0, 0, 2, 1, 1, "R3 R7 rd s1 -> wr s2");
    pair(3, 0, 0, 0, 0, 3, "R3 R7 rd s3 -> rd s0");
    pair(0, 0, 0, 1, 0, 0, "R3 rd s0 -> rd s1 zero field");
    pair(2, 0, 0, 2, 1, 2, "R2 rd s2 -> wr s2");
    pair(0, 0, 0, 0, 1, 1, "R2 R5 rd s0 -> wr s0");
    pair(1, 0, 0, 1, 0, 1, "R5 rd s1 -> rd s1");
    pair(2, 1, 0, 2, 1, 1, "R5 R6 wr s2 -> wr s2");
    pair(3, 1, 0, 0, 0, 0, "R6 wr s3 -> rd s0");
    pair(3, 1, 0, 2, 1, 0, "R6 wr s3 -> wr s2");
    pair(3, 0, 1, 0, 0, 3, "R4 rd s3 idle1 -> rd s0");
    pair(3, 0, 2, 3, 1, 3, "R4 rd s3 idle2 -> wr s3");
    pair(2, 0, 1, 1, 1, 2, "R4 rd s2 idle1 -> wr s1");
    pair(3, 0, 5, 1, 0, 5, "R4 R10 rd s3 idle5 -> rd s1");

    cfg_idle = 8'h00;
    pair(1, 0, 0, 2, 1, 0, "R3 zero fields rd s1 -> wr s2");
    cfg_idle = 8'hFF;
    pair(0, 0, 0, 1, 0, 3, "R3 R7 all three rd s0 -> rd s1");
    pair(1, 1, 0, 0, 1, 0, "R6 all three wr s1 -> wr s0");
    cfg_idle = 8'b00_00_11_00;
    pair(1, 0, 0, 3, 0, 3, "R7 read-space field used");
    pair(3, 0, 0, 1, 0, 0, "R7 requested-space field ignored");

    repeat (4) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule